// File: doc/BRIEF.md
# Indexed-Window Interrupt Controller

This block collects a wide vector of interrupt request lines and drives a single interrupt line toward a small 8-bit processor. Each configurable source has an enable bit and a trigger-mode bit. Edge sources latch a rising request until it is serviced. Level sources stay a candidate for as long as their line is high. When several candidates are present, the lowest-numbered one is taken into service. The interrupt output stays high until software sends an end-of-interrupt command. At that point the next candidate, if any, is taken in the same clock edge.

Software reaches every setting through two bus locations. Location 0 holds an index. Location 1 is a byte window into the bank that the index selects: the enable mask, the mode mask, the number of the in-service source, or a command slot. A write cycle presents a dummy value during its first cycle and the real value afterwards. The block therefore commits a write only at the clock edge where chip select is seen low again, and it takes the data present at that edge.

Top module: `pic_idx_top`

## Requirements
- R1: After reset the interrupt output is low, the index reads 0x00, every enable and mode byte reads 0x00 (all sources disabled, all edge mode), and the in-service number reads 0xFF.
- R2: A write commits the value present on the write data bus at the first rising edge where chip select is sampled low after a write cycle. The dummy 0xFF shown during the first cycle of the window is never stored.
- R3: With the index set to 0x1n (n = 0..15), location 1 reads and writes the enable byte for sources 8n to 8n+7, with source 8n in bit 0.
- R4: With the index set to 0x2n, location 1 reads and writes the mode byte in the same layout. A 0 bit selects edge trigger and a 1 bit selects level trigger.
- R5: An enabled request raised before a rising edge makes the interrupt output high right after that edge. A request on a disabled source leaves the output low.
- R6: Writing 0x01 at location 1 while the index holds 0xFF is end-of-interrupt. For an edge source with no other candidate, it drops the output even though the line is still high, and the output stays low when the line later falls. The in-service source does not change until end-of-interrupt.
- R7: For a level source, end-of-interrupt while its line is high leaves the output high. End-of-interrupt after the line has fallen drops the output.
- R8: Among candidates the lowest-numbered source is taken into service. With the index at 0x00, location 1 reads that source number, or 0xFF when nothing is in service.
- R9: End-of-interrupt while other edge requests are latched keeps the output high and moves service to the next-lowest latched source in the same edge.
- R10: Request inputs 128 to 255 never raise the output.
- R11: Data writes at unused indices change nothing, and unused indices read 0x00. A data value other than 0x01 at index 0xFF is not end-of-interrupt.
- R12: The read data bus is 0x00 whenever chip select is low or the cycle is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs | input | 1 | Chip select, active high |
| bus_rd_nwr | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 1 | 0 = index register, 1 = data window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| irq_req | input | 256 | Interrupt request lines |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
A corrupted enable or mode bit shows at the data window on the next read of its byte. It also shows at the interrupt line within one edge of a request on that source, as a missing or unexpected assertion. A wrong latch or in-service state shows at the next end-of-interrupt: the number read back at index 0x00 no longer steps through the requested sources in ascending order, or the output fails to drop or to stay high as the trigger mode requires. Random masks and request sets are drained one end-of-interrupt at a time, so any ordering fault appears within a few bus transactions.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int DW = 8;

    localparam logic [3:0] GRP_ENABLE = 4'h1;
    localparam logic [3:0] GRP_MODE   = 4'h2;
    localparam logic [7:0] IDX_SVC    = 8'h00;
    localparam logic [7:0] IDX_CMD    = 8'hFF;
    localparam logic [7:0] CMD_EOI    = 8'h01;
    localparam logic [7:0] ID_NONE    = 8'hFF;

    typedef enum logic [2:0] {
        BK_NONE,
        BK_SVC,
        BK_ENABLE,
        BK_MODE,
        BK_CMD
    } bank_e;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } data_wr_t;

    function automatic bank_e bank_of(input logic [7:0] idx, input int nbytes);
        bank_e b;
        b = BK_NONE;
        if (idx == IDX_SVC)
            b = BK_SVC;
        else if (idx == IDX_CMD)
            b = BK_CMD;
        else if (idx[7:4] == GRP_ENABLE && int'(idx[3:0]) < nbytes)
            b = BK_ENABLE;
        else if (idx[7:4] == GRP_MODE && int'(idx[3:0]) < nbytes)
            b = BK_MODE;
        return b;
    endfunction

endpackage

// File: rtl/pic_bus_port.sv
module pic_bus_port
    import pic_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_cs,
    input  logic          bus_rd_nwr,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] index_q,
    output data_wr_t      data_wr
);

    logic wr_now;
    logic wr_q;
    logic sel_q;
    logic commit;

    assign wr_now = bus_cs && !bus_rd_nwr;
    // the window closes at the first edge that sees the strobe gone
    assign commit = wr_q && !wr_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b0;
            sel_q   <= 1'b0;
            index_q <= '0;
        end else begin
            wr_q <= wr_now;
            if (wr_now)
                sel_q <= bus_addr;
            if (commit && !sel_q)
                index_q <= bus_wdata;
        end
    end

    always_comb begin
        data_wr.valid = commit && sel_q;
        data_wr.data  = bus_wdata;
    end

    p_index_only_on_commit_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(index_q) |-> $past(wr_q && !(bus_cs && !bus_rd_nwr)));

endmodule

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
    import pic_pkg::*;
#(
    parameter int N_CFG = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DW-1:0]    index_q,
    input  data_wr_t         data_wr,
    output logic [N_CFG-1:0] en_q,
    output logic [N_CFG-1:0] mode_q,
    output logic             eoi
);

    localparam int NB = N_CFG / 8;

    bank_e bank;

    assign bank = bank_of(index_q, NB);
    assign eoi  = data_wr.valid && bank == BK_CMD && data_wr.data == CMD_EOI;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[b*8 +: 8]   <= '0;
                mode_q[b*8 +: 8] <= '0;
            end else if (data_wr.valid && index_q[3:0] == 4'(b)) begin
                if (bank == BK_ENABLE)
                    en_q[b*8 +: 8] <= data_wr.data;
                if (bank == BK_MODE)
                    mode_q[b*8 +: 8] <= data_wr.data;
            end
        end
    end

    p_en_only_on_write_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(en_q) |-> $past(data_wr.valid));

    p_mode_only_on_write_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_q) |-> $past(data_wr.valid));

endmodule

// File: rtl/pic_lowest_pick.sv
module pic_lowest_pick #(
    parameter int N  = 128,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] id
);

    always_comb begin
        valid = |req;
        id    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i])
                id = IW'(i);
        end
    end

    p_pick_is_set_r8: assert property (@(posedge clk) disable iff (rst)
        valid |-> req[id]);

    p_pick_is_lowest_r8: assert property (@(posedge clk) disable iff (rst)
        valid |-> ((req & ~({N{1'b1}} << id)) == '0));

endmodule

// File: rtl/pic_core.sv
module pic_core #(
    parameter int N_CFG = 128,
    parameter int IW    = $clog2(N_CFG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CFG-1:0] req,
    input  logic [N_CFG-1:0] en,
    input  logic [N_CFG-1:0] mode,
    input  logic             eoi,
    output logic             svc_valid,
    output logic [IW-1:0]    svc_id
);

    logic [N_CFG-1:0] req_q;
    logic [N_CFG-1:0] pend_q;
    logic [N_CFG-1:0] pend_d;
    logic [N_CFG-1:0] edge_hit;
    logic [N_CFG-1:0] cand;
    logic             g_valid;
    logic [IW-1:0]    g_id;
    logic             reselect;

    always_comb begin
        edge_hit = req & ~req_q & en & ~mode;
        cand     = ((pend_q | edge_hit) & en & ~mode) | (req & en & mode);
    end

    pic_lowest_pick #(.N(N_CFG), .IW(IW)) i_pick (
        .clk   (clk),
        .rst   (rst),
        .req   (cand),
        .valid (g_valid),
        .id    (g_id)
    );

    assign reselect = eoi || !svc_valid;

    always_comb begin
        pend_d = pend_q | edge_hit;
        if (reselect && g_valid)
            pend_d[g_id] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= '0;
            pend_q    <= '0;
            svc_valid <= 1'b0;
            svc_id    <= '0;
        end else begin
            req_q  <= req;
            pend_q <= pend_d;
            if (reselect) begin
                svc_valid <= g_valid;
                svc_id    <= g_id;
            end
        end
    end

    p_hold_until_eoi_r6: assert property (@(posedge clk) disable iff (rst)
        (svc_valid && !eoi) |=> (svc_valid && $stable(svc_id)));

endmodule

// File: rtl/pic_idx_top.sv
module pic_idx_top
    import pic_pkg::*;
#(
    parameter int N_REQ = 256,
    parameter int N_CFG = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_cs,
    input  logic             bus_rd_nwr,
    input  logic             bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [N_REQ-1:0] irq_req,
    output logic             irq_out
);

    localparam int NB = N_CFG / 8;
    localparam int IW = $clog2(N_CFG);

    logic [DW-1:0]    index_q;
    data_wr_t         data_wr;
    logic [N_CFG-1:0] en_q;
    logic [N_CFG-1:0] mode_q;
    logic             eoi;
    logic             svc_valid;
    logic [IW-1:0]    svc_id;
    logic             unused_upper;

    assign unused_upper = ^irq_req[N_REQ-1:N_CFG];

    pic_bus_port i_bus (
        .clk        (clk),
        .rst        (rst),
        .bus_cs     (bus_cs),
        .bus_rd_nwr (bus_rd_nwr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .index_q    (index_q),
        .data_wr    (data_wr)
    );

    pic_cfg_regs #(.N_CFG(N_CFG)) i_cfg (
        .clk     (clk),
        .rst     (rst),
        .index_q (index_q),
        .data_wr (data_wr),
        .en_q    (en_q),
        .mode_q  (mode_q),
        .eoi     (eoi)
    );

    pic_core #(.N_CFG(N_CFG), .IW(IW)) i_core (
        .clk       (clk),
        .rst       (rst),
        .req       (irq_req[N_CFG-1:0]),
        .en        (en_q),
        .mode      (mode_q),
        .eoi       (eoi),
        .svc_valid (svc_valid),
        .svc_id    (svc_id)
    );

    assign irq_out = svc_valid;

    always_comb begin
        bus_rdata = '0;
        if (bus_cs && bus_rd_nwr) begin
            if (!bus_addr) begin
                bus_rdata = index_q;
            end else begin
                unique case (bank_of(index_q, NB))
                    BK_SVC:    bus_rdata = svc_valid ? 8'(svc_id) : ID_NONE;
                    BK_ENABLE: bus_rdata = en_q[int'(index_q[3:0]) * 8 +: 8];
                    BK_MODE:   bus_rdata = mode_q[int'(index_q[3:0]) * 8 +: 8];
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end

    p_low_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_out);

    p_idle_bus_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !bus_cs |-> bus_rdata == '0);

endmodule

// File: tb/test_pic_idx_top.sv
`timescale 1ns/1ps
module test_pic_idx_top;

    localparam real HALF = 2.5;

    logic         clk = 1'b0;
    logic         rst;
    logic         bus_cs;
    logic         bus_rd_nwr;
    logic         bus_addr;
    logic [7:0]   bus_wdata;
    logic [7:0]   bus_rdata;
    logic [255:0] irq_req;
    logic         irq_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #HALF clk = ~clk;

    pic_idx_top i_pic_idx_top (
        .clk        (clk),
        .rst        (rst),
        .bus_cs     (bus_cs),
        .bus_rd_nwr (bus_rd_nwr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_req    (irq_req),
        .irq_out    (irq_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_rd_nwr = 1'b0; bus_addr = a; bus_wdata = 8'hFF;
        @(posedge clk);
        #1 bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_rd_nwr = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_rd_nwr = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_cs = 1'b0;
    endtask

    task automatic rd_idx(input logic [7:0] idx, output logic [7:0] d);
        wr(1'b0, idx);
        rd(1'b1, d);
    endtask

    task automatic eoi();
        wr(1'b0, 8'hFF);
        wr(1'b1, 8'h01);
    endtask

    task automatic set_req(input logic [255:0] v);
        @(negedge clk);
        irq_req = v;
        @(posedge clk);
        #1;
    endtask

    function automatic int lowest(input logic [127:0] v);
        for (int i = 0; i < 128; i++)
            if (v[i]) return i;
        return 255;
    endfunction

    initial begin
        #(HALF * 2 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]   d;
        logic [127:0] en_m;
        logic [127:0] lines;
        logic [127:0] left;
        logic [7:0]   shadow [0:31];
        void'($urandom(32'd5150));

        rst = 1'b1; bus_cs = 1'b0; bus_rd_nwr = 1'b1; bus_addr = 1'b0;
        bus_wdata = 8'h00; irq_req = '0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        check("R1 irq_out", int'(irq_out), 0);
        rd(1'b0, d);          check("R1 index", d, 8'h00);
        rd(1'b1, d);          check("R1 svc none", d, 8'hFF);
        rd_idx(8'h10, d);     check("R1 enable byte0", d, 0);
        rd_idx(8'h2F, d);     check("R1 mode byte15", d, 0);

        // R2 committed value is the final one, not the first-cycle 0xFF
        wr(1'b0, 8'h5A);
        rd(1'b0, d);          check("R2 index commit", d, 8'h5A);
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h3C);
        rd(1'b1, d);          check("R2 data commit", d, 8'h3C);

        // R3 R4 random byte readback
        for (int k = 0; k < 32; k++) shadow[k] = 8'h00;
        shadow[3] = 8'h3C;
        for (int k = 0; k < 24; k++) begin
            int b;
            logic [7:0] v;
            logic md;
            b  = int'($urandom_range(15, 0));
            md = 1'($urandom_range(1, 0));
            v  = 8'($urandom);
            wr(1'b0, {md ? 4'h2 : 4'h1, 4'(b)});
            wr(1'b1, v);
            shadow[md ? 16 + b : b] = v;
        end
        for (int b = 0; b < 16; b++) begin
            rd_idx({4'h1, 4'(b)}, d); check("R3 enable readback", d, shadow[b]);
            rd_idx({4'h2, 4'(b)}, d); check("R4 mode readback", d, shadow[16 + b]);
        end

        // R11 unused index and non-EOI command
        wr(1'b0, 8'h33);
        wr(1'b1, 8'hAB);
        rd(1'b1, d);          check("R11 unused reads zero", d, 0);
        rd_idx(8'h10, d);     check("R11 enable untouched", d, shadow[0]);

        // R12 idle bus quiet
        @(negedge clk); #1;   check("R12 idle rdata", bus_rdata, 0);
        @(negedge clk);
        bus_cs = 1'b1; bus_rd_nwr = 1'b0; bus_addr = 1'b0; #1;
        check("R12 write rdata", bus_rdata, 0);
        bus_cs = 1'b0; bus_rd_nwr = 1'b1;
        @(posedge clk);

        // clean configuration
        for (int b = 0; b < 16; b++) begin
            wr(1'b0, {4'h1, 4'(b)}); wr(1'b1, 8'h00);
            wr(1'b0, {4'h2, 4'(b)}); wr(1'b1, 8'h00);
        end
        eoi();
        check("R1 clean idle", int'(irq_out), 0);

        // R5 disabled source silent, enabled source fires after one edge
        wr(1'b0, 8'h10); wr(1'b1, 8'h08);
        set_req(256'h20);
        @(posedge clk); #1;
        check("R5 disabled silent", int'(irq_out), 0);
        set_req(256'h28);
        check("R5 enabled fires", int'(irq_out), 1);
        rd_idx(8'h00, d);     check("R8 svc number", d, 3);

        // R11 wrong command code keeps service
        wr(1'b0, 8'hFF); wr(1'b1, 8'h02);
        check("R11 non-eoi code", int'(irq_out), 1);

        // R6 edge EOI with line still high
        eoi();
        check("R6 edge eoi drops", int'(irq_out), 0);
        set_req(256'h20);
        @(posedge clk); #1;
        check("R6 stays low on fall", int'(irq_out), 0);
        rd_idx(8'h00, d);     check("R6 none in service", d, 8'hFF);

        // R7 level behaviour
        wr(1'b0, 8'h20); wr(1'b1, 8'h08);
        set_req(256'h08);
        check("R7 level fires", int'(irq_out), 1);
        eoi();
        check("R7 level held", int'(irq_out), 1);
        set_req(256'h00);
        @(posedge clk); #1;
        check("R7 waits for eoi", int'(irq_out), 1);
        eoi();
        check("R7 level drops", int'(irq_out), 0);
        wr(1'b0, 8'h20); wr(1'b1, 8'h00);

        // R10 upper inputs ignored
        for (int b = 0; b < 16; b++) begin
            wr(1'b0, {4'h1, 4'(b)}); wr(1'b1, 8'hFF);
        end
        set_req({1'b1, 54'd0, 1'b1, 72'd0, 128'd0});
        @(posedge clk); #1;
        check("R10 upper ignored", int'(irq_out), 0);
        rd_idx(8'h00, d);     check("R10 none in service", d, 8'hFF);
        set_req('0);

        // R8 R9 random masks and request sets, drained by EOI
        for (int r = 0; r < 6; r++) begin
            for (int w = 0; w < 4; w++) en_m[w*32 +: 32] = $urandom;
            for (int w = 0; w < 4; w++)
                lines[w*32 +: 32] = $urandom & $urandom & $urandom;
            lines[r * 7] = 1'b1;
            en_m[r * 7]  = 1'b1;
            for (int b = 0; b < 16; b++) begin
                wr(1'b0, {4'h1, 4'(b)}); wr(1'b1, en_m[b*8 +: 8]);
            end
            set_req({128'd0, lines});
            left = lines & en_m;
            while (left != '0) begin
                int exp;
                exp = lowest(left);
                check("R9 output held", int'(irq_out), 1);
                rd_idx(8'h00, d); check("R8 lowest first", d, exp);
                left[exp] = 1'b0;
                eoi();
            end
            check("R6 drained low", int'(irq_out), 0);
            rd_idx(8'h00, d);     check("R8 drained none", d, 8'hFF);
            set_req('0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule